// File: doc/BRIEF.md
# LED Blink PWM Controller

This block drives one LED pin with a duty-cycled waveform. Software programs it through a small word-addressed register file on a synchronous write bus with a combinational read port. A mode field chooses between holding the pin low, holding it high, and pulsing it. In pulse mode an 8-bit phase counter divides each period into 256 slots. The pin is high while the phase is below the duty value. A 12-bit prescaler stretches every slot to (LD+1) ticks, so one period lasts 256×(LD+1) ticks. A CONFIG bit chooses which of two tick-enable inputs drives the counters. One input stands for a fast clock and the other for a slow clock.

The duty value takes effect as soon as it is written. The prescaler value is different: software writes it into a holding register, then requests a transfer by writing 1 to an update bit. The holding value becomes active only at the next period boundary, which prevents a period of mixed length. A self-clearing soft-reset bit zeroes the counters.

The pin is driven by a three-state machine: ST_LOW, ST_PULSE and ST_HIGH. On every clock it takes one of three transitions, each chosen by the CONFIG mode field and allowed from any state:
- `to_low`: mode 0 or mode 1.
- `to_pulse`: mode 2.
- `to_high`: mode 3.

Top module: `led_blink_pwm`

**Register map** (word address on `bus_addr`):

| Address | Register | Fields |
|---|---|---|
| 0 | CONFIG (17 bits, reset 0x01400) | [1:0] mode, [2] fast tick select, [6] update request/pending, [7] soft reset, [15:8] reload byte (default 0x14) |
| 1 | LIMITS (16 bits) | [7:0] duty, [15:8] upper byte (stored only) |
| 2 | DELAY (24 bits) | [11:0] held LD, [23:12] second delay field (stored only) |
| 3 | OUTPUT_DELAY (8 bits) | stored only |

## Requirements
- R1: With CONFIG[1:0] equal to 0 or 1, `led_out` is 0.
- R2: With CONFIG[1:0] equal to 3, `led_out` is 1.
- R3: In mode 2, every period lasts 256×(LD+1) selected ticks. In each period `led_out` is high for duty×(LD+1) ticks, where duty is LIMITS[7:0] and the phase counter counts 0..255.
- R4: In mode 2, a duty of 0 keeps `led_out` low and a duty of 255 keeps it high.
- R5: A LIMITS write changes `led_out` in the clock cycle that follows the write edge. In that cycle the pin is high exactly when the current phase is below the new duty.
- R6: CONFIG[2]=1 selects `tick_fast` and CONFIG[2]=0 selects `tick_slow`. Ticks on the unselected input do not advance the counters.
- R7: A DELAY write only loads the holding register. The active LD keeps its old value until a transfer happens.
- R8: Writing 1 to CONFIG[6] sets a pending flag, which reads back as 1. At the first period boundary that follows the request, the held LD becomes active and the flag clears. A request whose write lands on the boundary cycle itself waits for the next boundary. Writing 0 to CONFIG[6] leaves the flag unchanged.
- R9: A write with CONFIG[7]=1 zeroes the prescaler and the phase counter at that edge, and this takes precedence over a tick. CONFIG[7] always reads 0.
- R10: After reset, CONFIG reads 0x01400 and the other registers read 0. LIMITS[15:8], DELAY[23:12] and OUTPUT_DELAY[7:0] read back whatever was last written to them.
- R11: A mode change reaches `led_out` one clock cycle after the CONFIG write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 2 | Word address of register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tick_fast | input | 1 | Fast tick enable |
| tick_slow | input | 1 | Slow tick enable |
| led_out | output | 1 | LED pin drive |

## Verification
Two functions can fall in the same cycle: a software update request and the hardware period boundary that performs the staged prescaler transfer. To provoke this, the bench first uses a soft reset to align the phase at LD=0, with a tick on every cycle. It then counts clocks so that the CONFIG write setting the update bit lands exactly on the edge where the phase wraps from 255 to 0. The result is judged at the ports: the pending bit must still read 1 one full period later and must read 0 only after the following boundary. Soft reset racing a tick is judged the same way, through the pin level right after the reset edge.

// File: rtl/led_pwm_pkg.sv
package led_pwm_pkg;
    localparam int CFG_W       = 17;
    localparam int CFG_FAST    = 2;
    localparam int CFG_UPD     = 6;
    localparam int CFG_SRST    = 7;
    localparam logic [CFG_W-1:0] CFG_RST = 17'h01400;

    localparam logic [1:0] MODE_PULSE = 2'd2;
    localparam logic [1:0] MODE_HIGH  = 2'd3;

    localparam logic [1:0] A_CFG  = 2'd0;
    localparam logic [1:0] A_LIM  = 2'd1;
    localparam logic [1:0] A_DLY  = 2'd2;
    localparam logic [1:0] A_ODLY = 2'd3;

    typedef enum logic [1:0] {
        ST_LOW   = 2'd0,
        ST_PULSE = 2'd1,
        ST_HIGH  = 2'd2
    } drv_state_t;
endpackage

// File: rtl/led_pwm_regfile.sv
module led_pwm_regfile
    import led_pwm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LD_W   = 12,
    parameter int DUTY_W = 8,
    parameter int ODLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              upd_done,
    output logic [1:0]        mode,
    output logic              fast_sel,
    output logic              upd_pend,
    output logic              soft_rst,
    output logic [DUTY_W-1:0] duty,
    output logic [LD_W-1:0]   ld_hold
);
    localparam int LIM_W = 2 * DUTY_W;
    localparam int DLY_W = 2 * LD_W;

    logic [CFG_W-1:0]  cfg_q, cfg_n;
    logic [LIM_W-1:0]  lim_q;
    logic [DLY_W-1:0]  dly_q;
    logic [ODLY_W-1:0] odly_q;
    logic wr_cfg;

    assign wr_cfg   = bus_we && (bus_addr == A_CFG);
    assign soft_rst = wr_cfg && bus_wdata[CFG_SRST];

    always_comb begin
        cfg_n = cfg_q;
        if (wr_cfg) begin
            cfg_n = bus_wdata[CFG_W-1:0];
            cfg_n[CFG_SRST] = 1'b0;
        end
        cfg_n[CFG_UPD] = (cfg_q[CFG_UPD] && !upd_done) || (wr_cfg && bus_wdata[CFG_UPD]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q  <= CFG_RST;
            lim_q  <= '0;
            dly_q  <= '0;
            odly_q <= '0;
        end else begin
            cfg_q <= cfg_n;
            if (bus_we && bus_addr == A_LIM)  lim_q  <= bus_wdata[LIM_W-1:0];
            if (bus_we && bus_addr == A_DLY)  dly_q  <= bus_wdata[DLY_W-1:0];
            if (bus_we && bus_addr == A_ODLY) odly_q <= bus_wdata[ODLY_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_CFG:   bus_rdata[CFG_W-1:0]  = cfg_q;
            A_LIM:   bus_rdata[LIM_W-1:0]  = lim_q;
            A_DLY:   bus_rdata[DLY_W-1:0]  = dly_q;
            default: bus_rdata[ODLY_W-1:0] = odly_q;
        endcase
    end

    assign mode     = cfg_q[1:0];
    assign fast_sel = cfg_q[CFG_FAST];
    assign upd_pend = cfg_q[CFG_UPD];
    assign duty     = lim_q[DUTY_W-1:0];
    assign ld_hold  = dly_q[LD_W-1:0];
endmodule

// File: rtl/led_pwm_timebase.sv
module led_pwm_timebase #(
    parameter int LD_W = 12,
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_fast,
    input  logic            tick_slow,
    input  logic            fast_sel,
    input  logic            soft_rst,
    input  logic            upd_pend,
    input  logic [LD_W-1:0] ld_hold,
    output logic [LD_W-1:0] pre_cnt,
    output logic [LD_W-1:0] ld_act,
    output logic [PH_W-1:0] phase,
    output logic            wrap,
    output logic            upd_done
);
    logic tick, at_ld;

    assign tick     = fast_sel ? tick_fast : tick_slow;
    assign at_ld    = (pre_cnt == ld_act);
    assign wrap     = tick && at_ld && (phase == '1);
    assign upd_done = wrap && upd_pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt <= '0;
            phase   <= '0;
        end else if (soft_rst) begin
            pre_cnt <= '0;
            phase   <= '0;
        end else if (tick) begin
            if (at_ld) begin
                pre_cnt <= '0;
                phase   <= phase + 1'b1;
            end else begin
                pre_cnt <= pre_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ld_act <= '0;
        else if (upd_done) ld_act <= ld_hold;
    end
endmodule

// File: rtl/led_pwm_drive.sv
module led_pwm_drive
    import led_pwm_pkg::*;
#(
    parameter int PH_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode,
    input  logic [PH_W-1:0] duty,
    input  logic [PH_W-1:0] phase,
    output logic            led_out
);
    drv_state_t state_q, state_n;

    always_comb begin
        unique case (mode)
            MODE_PULSE: state_n = ST_PULSE;
            MODE_HIGH:  state_n = ST_HIGH;
            default:    state_n = ST_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_n;
    end

    always_comb begin
        unique case (state_q)
            ST_PULSE: led_out = (duty == '1) || (phase < duty);
            ST_HIGH:  led_out = 1'b1;
            default:  led_out = 1'b0;
        endcase
    end
endmodule

// File: rtl/led_blink_pwm.sv
module led_blink_pwm #(
    parameter int DATA_W = 32,
    parameter int LD_W   = 12,
    parameter int PH_W   = 8,
    parameter int ODLY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tick_fast,
    input  logic              tick_slow,
    output logic              led_out
);
    logic [1:0]      mode;
    logic            fast_sel, upd_pend, soft_rst, upd_done, wrap;
    logic [PH_W-1:0] duty, phase;
    logic [LD_W-1:0] ld_hold, ld_act, pre_cnt;

    led_pwm_regfile #(.DATA_W(DATA_W), .LD_W(LD_W), .DUTY_W(PH_W), .ODLY_W(ODLY_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .upd_done(upd_done),
        .mode(mode), .fast_sel(fast_sel), .upd_pend(upd_pend), .soft_rst(soft_rst),
        .duty(duty), .ld_hold(ld_hold)
    );

    led_pwm_timebase #(.LD_W(LD_W), .PH_W(PH_W)) u_time (
        .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .tick_slow(tick_slow),
        .fast_sel(fast_sel), .soft_rst(soft_rst), .upd_pend(upd_pend),
        .ld_hold(ld_hold), .pre_cnt(pre_cnt), .ld_act(ld_act), .phase(phase),
        .wrap(wrap), .upd_done(upd_done)
    );

    led_pwm_drive #(.PH_W(PH_W)) u_drive (
        .clk(clk), .rst_n(rst_n), .mode(mode), .duty(duty), .phase(phase),
        .led_out(led_out)
    );
endmodule

// File: rtl/led_pwm_chk.sv
module led_pwm_chk #(
    parameter int LD_W = 12,
    parameter int PH_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      mode,
    input logic            led_out,
    input logic            upd_pend,
    input logic            wrap,
    input logic            soft_rst,
    input logic [LD_W-1:0] ld_act,
    input logic [LD_W-1:0] pre_cnt,
    input logic [PH_W-1:0] phase
);
    assert_off_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd0 || $past(mode) == 2'd1) |-> !led_out);

    assert_on_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'd3) |-> led_out);

    assert_pre_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= ld_act);

    assert_ld_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wrap) |-> $stable(ld_act));

    assert_pend_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(upd_pend) |-> $past(wrap));

    assert_srst_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_rst) |-> (phase == '0 && pre_cnt == '0));
endmodule

bind led_blink_pwm led_pwm_chk #(.LD_W(LD_W), .PH_W(PH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .led_out(led_out),
    .upd_pend(upd_pend), .wrap(wrap), .soft_rst(soft_rst),
    .ld_act(ld_act), .pre_cnt(pre_cnt), .phase(phase)
);

// File: tb/sim_led_blink_pwm.sv
`timescale 1ns/1ps
module sim_led_blink_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        tick_fast = 1'b0;
    logic        tick_slow = 1'b0;
    logic        led_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam logic [31:0] C_PULSE = 32'h1406;
    localparam logic [31:0] C_SRST  = 32'h1486;
    localparam logic [31:0] C_UPD   = 32'h1446;
    localparam logic [31:0] C_SLOW  = 32'h1402;

    always #2.5 clk = ~clk;

    led_blink_pwm u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_fast(tick_fast),
        .tick_slow(tick_slow), .led_out(led_out)
    );

    // slow tick: one cycle in four, changed away from the rising edge
    initial begin
        int k = 0;
        forever begin
            @(negedge clk);
            tick_slow = (k == 3);
            k = (k + 1) % 4;
        end
    end

    initial begin
        #500us;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    // called at a falling edge; write lands on the next rising edge; returns at a falling edge
    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic count_high(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (led_out) c++;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        rd(2'd0, d); check("R10 config reset", d, 32'h1400);
        rd(2'd1, d); check("R10 limits reset", d, 0);
        rd(2'd2, d); check("R10 delay reset", d, 0);
        rd(2'd3, d); check("R10 outdly reset", d, 0);
        check("R1 pin low after reset", led_out, 0);
    endtask

    task automatic t_readback;
        logic [31:0] d;
        wr(2'd1, 32'h0000_C300);
        wr(2'd2, 32'h00AB_C000);
        wr(2'd3, 32'h0000_005A);
        rd(2'd1, d); check("R10 limits upper byte", d, 32'hC300);
        rd(2'd2, d); check("R10 delay upper field", d, 32'hABC000);
        rd(2'd3, d); check("R10 outdly field", d, 32'h5A);
        wr(2'd2, 32'h0);
        wr(2'd0, 32'h1480);
        rd(2'd0, d); check("R9 soft reset bit reads 0", d, 32'h1400);
    endtask

    task automatic t_modes;
        wr(2'd0, 32'h1407);
        check("R11 pin lags mode write", led_out, 0);
        @(negedge clk);
        check("R2 mode 3 drives high", led_out, 1);
        wr(2'd0, 32'h1405);
        @(negedge clk);
        check("R1 mode 1 drives low", led_out, 0);
        wr(2'd0, 32'h1407);
        @(negedge clk);
        wr(2'd0, 32'h1404);
        @(negedge clk);
        check("R1 mode 0 drives low", led_out, 0);
    endtask

    task automatic t_duty;
        int c;
        tick_fast = 1'b1;
        wr(2'd0, C_PULSE);
        wr(2'd1, 32'd64);  count_high(256, c); check("R3 duty 64 ld 0", c, 64);
        wr(2'd1, 32'd200); count_high(256, c); check("R3 duty 200 ld 0", c, 200);
        wr(2'd1, 32'd1);   count_high(256, c); check("R3 duty 1", c, 1);
        wr(2'd1, 32'd254); count_high(256, c); check("R3 duty 254", c, 254);
        wr(2'd1, 32'd0);   count_high(256, c); check("R4 duty 0 always low", c, 0);
        wr(2'd1, 32'd255); count_high(256, c); check("R4 duty 255 always high", c, 256);
    endtask

    task automatic t_immediate;
        wr(2'd1, 32'd1);
        wr(2'd0, C_SRST);
        check("R9 phase zero after soft reset", led_out, 1);
        @(negedge clk);
        check("R9 phase advanced to 1", led_out, 0);
        wr(2'd0, C_SRST);
        wr(2'd1, 32'd0);
        wr(2'd1, 32'd128);
        check("R5 new duty applies at once (phase 2 < 128)", led_out, 1);
        wr(2'd1, 32'd2);
        check("R5 new duty applies at once (phase 3 >= 2)", led_out, 0);
    endtask

    task automatic t_ticksel;
        int c;
        wr(2'd1, 32'd64);
        wr(2'd0, C_SLOW);
        count_high(1024, c); check("R6 slow tick stretches period", c, 256);
        tick_fast = 1'b0;
        wr(2'd1, 32'd1);
        wr(2'd0, C_SRST);
        tick_fast = 1'b0;
        count_high(300, c); check("R6 slow ticks ignored when fast selected", c, 300);
        tick_fast = 1'b1;
    endtask

    task automatic t_staged;
        int c;
        logic [31:0] d;
        wr(2'd1, 32'd64);
        wr(2'd2, 32'd1);
        count_high(256, c); check("R7 held LD not yet active", c, 64);
        wr(2'd0, C_UPD);
        rd(2'd0, d); check("R8 pending reads 1", d[6], 1);
        repeat (260) @(negedge clk);
        rd(2'd0, d); check("R8 pending clears after boundary", d[6], 0);
        count_high(512, c); check("R3 duty 64 ld 1", c, 128);
        wr(2'd0, C_PULSE);
        rd(2'd0, d); check("R8 writing 0 keeps flag clear", d[6], 0);
        wr(2'd2, 32'd0);
        wr(2'd0, C_UPD);
        repeat (600) @(negedge clk);
        count_high(256, c); check("R3 back to ld 0", c, 64);
    endtask

    task automatic t_boundary;
        logic [31:0] d;
        int c;
        wr(2'd2, 32'd3);
        wr(2'd0, C_SRST);
        repeat (255) @(negedge clk);
        wr(2'd0, C_UPD);
        rd(2'd0, d); check("R8 request on boundary edge stays pending", d[6], 1);
        repeat (254) @(negedge clk);
        rd(2'd0, d); check("R8 still pending before next boundary", d[6], 1);
        repeat (2) @(negedge clk);
        rd(2'd0, d); check("R8 transfer at following boundary", d[6], 0);
        count_high(1024, c); check("R3 duty 64 ld 3", c, 256);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_modes();
        t_duty();
        t_immediate();
        t_ticksel();
        t_staged();
        t_boundary();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule